// File: doc/BRIEF.md
# Inbound Bus Address Window Translator

This block sits behind a bus-target front end and decides where each incoming memory transaction lands in a 32-bit internal address space. It holds two address windows of fixed size. Window 0 spans 256 Kbyte and window 1 spans 1 Gbyte. Each window has a base register that places it in the incoming address space. Each also has a translation base that places a hit in the internal space, and an enable bit.

When an address is presented, the block compares only the bits above each window's size against that window's base. On a hit, the upper bits are replaced by the translation base and the offset bits are kept. A hit in a window whose enable is clear is reported as an abort. An address that hits neither window is flagged as no-match, so the front end can leave it alone. When both windows claim the address, window 0 decides the outcome. Software programs the windows through a small register write port and can read the stored values back through a read port.

The result path is a four-state machine. Its state register is the registered result class of the last cycle:
- ST_IDLE: no address was presented.
- ST_PASS: enabled hit.
- ST_ABORT: disabled hit.
- ST_MISS: no window hit.

Every cycle the state moves to one of these four according to that cycle's input:
- from any state to ST_IDLE when in_valid is low;
- to ST_PASS on a hit in an enabled winning window;
- to ST_ABORT on a hit in a disabled winning window;
- to ST_MISS when in_valid is high and neither window hits.

Top module: `inb_win_xlat`

## Requirements
- R1: Window 0 hits when in_addr[31:18] equals bits [31:18] of its base register (256 Kbyte window).
- R2: Window 1 hits when in_addr[31:30] equals bits [31:30] of its base register (1 Gbyte window).
- R3: On an enabled hit, out_addr is the winning window's translation base above the window size concatenated with in_addr below it, out_hit is 1 and out_win gives the window number.
- R4: When both windows hit, window 0 wins: out_win is 0, and window 0's enable alone decides between pass and abort.
- R5: A hit in a winning window whose enable bit is clear gives out_abort=1, out_hit=0, out_addr=0, with out_win naming that window.
- R6: An address that hits neither window gives out_no_match=1, out_abort=0, out_hit=0, out_win=0 and out_addr=0.
- R7: The register codes are: 0 window 0 base, 1 window 1 base, 2 window 0 translation base, 3 window 1 translation base, 4 control with bit 0 the window 0 enable and bit 1 the window 1 enable. Base and translation bits below the window size are ignored on write and read back as zero. Codes 5 to 7 are ignored on write and read as zero. reg_rdata is combinational from reg_raddr.
- R8: All outputs are registered and due one clock edge after in_valid is sampled. A cycle without in_valid gives out_valid=0 and all flags and out_addr zero in the following cycle.
- R9: Reset clears all registers, including both enable bits, and holds all outputs at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_waddr | input | 3 | Register code for the write |
| reg_wdata | input | 32 | Write data |
| reg_raddr | input | 3 | Register code for read-back |
| reg_rdata | output | 32 | Read-back data |
| in_valid | input | 1 | Incoming address is valid this cycle |
| in_addr | input | 32 | Incoming memory transaction address |
| out_valid | output | 1 | A result for the previous cycle's address |
| out_hit | output | 1 | Enabled window hit, out_addr is valid |
| out_win | output | 1 | Window that decided the result |
| out_abort | output | 1 | Hit in a disabled window |
| out_no_match | output | 1 | No window hit |
| out_addr | output | 32 | Translated internal address |

## Verification
Every translation result is due exactly one clock edge after the address is sampled. The bench drives in_valid and in_addr on a falling edge and checks the result on the next falling edge, which is half a period after the capturing rising edge. Register writes take effect at that same rising edge. Read-back is combinational, so it is checked on the falling edge after a write, with no further wait. Window boundaries, overlap priority and disabled-window aborts are checked through that same one-edge schedule.

// File: rtl/inb_win_pkg.sv
package inb_win_pkg;

    localparam int REG_AW = 3;

    localparam logic [REG_AW-1:0] RA_BAR0 = 3'd0;
    localparam logic [REG_AW-1:0] RA_XB0  = 3'd2;
    localparam logic [REG_AW-1:0] RA_CTRL = 3'd4;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_PASS  = 2'd1,
        ST_ABORT = 2'd2,
        ST_MISS  = 2'd3
    } res_state_t;

endpackage

// File: rtl/inb_win_regs.sv
module inb_win_regs
    import inb_win_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int WIN0_LOG2 = 18,
    parameter int WIN1_LOG2 = 30
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    reg_we,
    input  logic [REG_AW-1:0]       reg_waddr,
    input  logic [ADDR_W-1:0]       reg_wdata,
    input  logic [REG_AW-1:0]       reg_raddr,
    output logic [ADDR_W-1:0]       reg_rdata,
    output logic [1:0][ADDR_W-1:0]  bar,
    output logic [1:0][ADDR_W-1:0]  xbase,
    output logic [1:0]              en
);

    logic [1:0][ADDR_W-1:0] bar_q;
    logic [1:0][ADDR_W-1:0] xb_q;
    logic [1:0]             en_q;

    for (genvar g = 0; g < 2; g++) begin : g_win
        localparam int          LG    = (g == 0) ? WIN0_LOG2 : WIN1_LOG2;
        localparam logic [ADDR_W-1:0] MASK = {ADDR_W{1'b1}} << LG;
        localparam logic [REG_AW-1:0] BAR_CODE = RA_BAR0 + REG_AW'(g);
        localparam logic [REG_AW-1:0] XB_CODE  = RA_XB0 + REG_AW'(g);

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                bar_q[g] <= '0;
                xb_q[g]  <= '0;
                en_q[g]  <= 1'b0;
            end else if (reg_we) begin
                if (reg_waddr == BAR_CODE) bar_q[g] <= reg_wdata & MASK;
                if (reg_waddr == XB_CODE)  xb_q[g]  <= reg_wdata & MASK;
                if (reg_waddr == RA_CTRL)  en_q[g]  <= reg_wdata[g];
            end
        end

        // base register low bits must never hold a one
        AST_BAR_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
            (reg_we && reg_waddr == BAR_CODE) |=> ((bar_q[g] & ~MASK) == '0)); // R7
    end

    always_comb begin
        reg_rdata = '0;
        unique case (reg_raddr)
            3'd0:    reg_rdata = bar_q[0];
            3'd1:    reg_rdata = bar_q[1];
            3'd2:    reg_rdata = xb_q[0];
            3'd3:    reg_rdata = xb_q[1];
            3'd4:    reg_rdata = {{(ADDR_W-2){1'b0}}, en_q};
            default: reg_rdata = '0;
        endcase
    end

    assign bar   = bar_q;
    assign xbase = xb_q;
    assign en    = en_q;

    AST_EN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_waddr == RA_CTRL) |=> (en_q == $past(reg_wdata[1:0]))); // R7

endmodule

// File: rtl/inb_win_match.sv
module inb_win_match #(
    parameter int ADDR_W = 32,
    parameter int LOG2   = 18
) (
    input  logic [ADDR_W-1:0] in_addr,
    input  logic [ADDR_W-1:0] bar,
    input  logic [ADDR_W-1:0] xbase,
    output logic              hit,
    output logic [ADDR_W-1:0] xaddr
);

    assign hit   = (in_addr[ADDR_W-1:LOG2] == bar[ADDR_W-1:LOG2]);
    assign xaddr = {xbase[ADDR_W-1:LOG2], in_addr[LOG2-1:0]};

endmodule

// File: rtl/inb_win_ctrl.sv
module inb_win_ctrl
    import inb_win_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   in_valid,
    input  logic [1:0]             hit,
    input  logic [1:0]             en,
    input  logic [1:0][ADDR_W-1:0] xaddr,
    output logic                   out_valid,
    output logic                   out_hit,
    output logic                   out_win,
    output logic                   out_abort,
    output logic                   out_no_match,
    output logic [ADDR_W-1:0]      out_addr
);

    res_state_t        state_q, state_d;
    logic              win_q, win_d;
    logic [ADDR_W-1:0] addr_q, addr_d;

    // next state: window 0 decides whenever it hits
    always_comb begin
        state_d = ST_IDLE;
        win_d   = 1'b0;
        addr_d  = '0;
        if (in_valid) begin
            if (hit[0]) begin
                win_d   = 1'b0;
                state_d = en[0] ? ST_PASS : ST_ABORT;
                addr_d  = en[0] ? xaddr[0] : '0;
            end else if (hit[1]) begin
                win_d   = 1'b1;
                state_d = en[1] ? ST_PASS : ST_ABORT;
                addr_d  = en[1] ? xaddr[1] : '0;
            end else begin
                state_d = ST_MISS;
            end
        end
    end

    // state register with its payload
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            win_q   <= 1'b0;
            addr_q  <= '0;
        end else begin
            state_q <= state_d;
            win_q   <= win_d;
            addr_q  <= addr_d;
        end
    end

    // outputs decoded from the registered state
    always_comb begin
        out_valid    = 1'b0;
        out_hit      = 1'b0;
        out_abort    = 1'b0;
        out_no_match = 1'b0;
        unique case (state_q)
            ST_IDLE:  ;
            ST_PASS:  begin out_valid = 1'b1; out_hit      = 1'b1; end
            ST_ABORT: begin out_valid = 1'b1; out_abort    = 1'b1; end
            ST_MISS:  begin out_valid = 1'b1; out_no_match = 1'b1; end
            default:  ;
        endcase
    end

    assign out_win  = win_q;
    assign out_addr = addr_q;

    AST_OUT_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid); // R8
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && !out_hit && !out_abort && !out_no_match && out_addr == '0)); // R8
    AST_DIS_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && hit[0] && !en[0]) |=> (out_abort && !out_hit && !out_win && out_addr == '0)); // R5
    AST_WIN0_PRIO: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && hit[0] && hit[1]) |=> (out_win == 1'b0)); // R4
    AST_MISS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && hit == 2'b00) |=> (out_no_match && !out_abort && !out_hit)); // R6

endmodule

// File: rtl/inb_win_xlat.sv
module inb_win_xlat
    import inb_win_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int WIN0_LOG2 = 18,
    parameter int WIN1_LOG2 = 30
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [2:0]        reg_waddr,
    input  logic [ADDR_W-1:0] reg_wdata,
    input  logic [2:0]        reg_raddr,
    output logic [ADDR_W-1:0] reg_rdata,
    input  logic              in_valid,
    input  logic [ADDR_W-1:0] in_addr,
    output logic              out_valid,
    output logic              out_hit,
    output logic              out_win,
    output logic              out_abort,
    output logic              out_no_match,
    output logic [ADDR_W-1:0] out_addr
);

    logic [1:0][ADDR_W-1:0] bar;
    logic [1:0][ADDR_W-1:0] xbase;
    logic [1:0][ADDR_W-1:0] xaddr;
    logic [1:0]             en;
    logic [1:0]             hit;

    inb_win_regs #(
        .ADDR_W(ADDR_W), .WIN0_LOG2(WIN0_LOG2), .WIN1_LOG2(WIN1_LOG2)
    ) u_regs (
        .clk(clk), .rst_n(rst_n),
        .reg_we(reg_we), .reg_waddr(reg_waddr), .reg_wdata(reg_wdata),
        .reg_raddr(reg_raddr), .reg_rdata(reg_rdata),
        .bar(bar), .xbase(xbase), .en(en)
    );

    for (genvar g = 0; g < 2; g++) begin : g_match
        localparam int LG = (g == 0) ? WIN0_LOG2 : WIN1_LOG2;
        inb_win_match #(.ADDR_W(ADDR_W), .LOG2(LG)) u_match (
            .in_addr(in_addr), .bar(bar[g]), .xbase(xbase[g]),
            .hit(hit[g]), .xaddr(xaddr[g])
        );
    end

    inb_win_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .hit(hit), .en(en), .xaddr(xaddr),
        .out_valid(out_valid), .out_hit(out_hit), .out_win(out_win),
        .out_abort(out_abort), .out_no_match(out_no_match), .out_addr(out_addr)
    );

    AST_OFFSET_KEEP0: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && hit[0] && en[0]) |=> (out_addr[WIN0_LOG2-1:0] == $past(in_addr[WIN0_LOG2-1:0]))); // R3
    AST_WIN1_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !hit[0] && hit[1] && en[1]) |=> (out_hit && out_win
            && out_addr[ADDR_W-1:WIN1_LOG2] == $past(xbase[1][ADDR_W-1:WIN1_LOG2]))); // R2

endmodule

// File: tb/sim_inb_win_xlat.sv
module sim_inb_win_xlat;

    localparam int CLK_PERIOD = 10;
    localparam int NV = 8;

    // kind: 1 pass, 2 abort, 3 miss
    localparam logic [31:0] V_ADDR [NV] = '{
        32'h8000_0000, 32'h8003_FFFF, 32'h8004_0000, 32'h7FFF_FFFF,
        32'h4000_0000, 32'h3FFF_FFFF, 32'h5555_1234, 32'h0000_0000};
    localparam logic [1:0] V_KIND [NV] = '{2'd1, 2'd1, 2'd3, 2'd1, 2'd1, 2'd3, 2'd1, 2'd3};
    localparam logic       V_WIN  [NV] = '{1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0};
    localparam logic [31:0] V_XADDR [NV] = '{
        32'h1234_0000, 32'h1237_FFFF, 32'h0000_0000, 32'hFFFF_FFFF,
        32'hC000_0000, 32'h0000_0000, 32'hD555_1234, 32'h0000_0000};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_waddr = '0;
    logic [31:0] reg_wdata = '0;
    logic [2:0]  reg_raddr = '0;
    logic [31:0] reg_rdata;
    logic        in_valid = 1'b0;
    logic [31:0] in_addr = '0;
    logic        out_valid, out_hit, out_win, out_abort, out_no_match;
    logic [31:0] out_addr;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    inb_win_xlat u0 (
        .clk(clk), .rst_n(rst_n),
        .reg_we(reg_we), .reg_waddr(reg_waddr), .reg_wdata(reg_wdata),
        .reg_raddr(reg_raddr), .reg_rdata(reg_rdata),
        .in_valid(in_valid), .in_addr(in_addr),
        .out_valid(out_valid), .out_hit(out_hit), .out_win(out_win),
        .out_abort(out_abort), .out_no_match(out_no_match), .out_addr(out_addr)
    );

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_waddr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic chk_rd(input string tag, input logic [2:0] a, input logic [31:0] exp);
        reg_raddr = a;
        #1;
        n_tests++;
        if (reg_rdata !== exp) begin
            n_fail++;
            $display("FAIL %s readback code %0d: got %h expected %h", tag, a, reg_rdata, exp);
        end
    endtask

    // drive on a falling edge, result due after the next rising edge
    task automatic probe(input string tag, input logic [31:0] a, input logic [1:0] kind,
                         input logic win, input logic [31:0] xa);
        logic [5:0] got, exp;
        logic [31:0] got_a;
        @(negedge clk);
        in_valid = 1'b1; in_addr = a;
        @(negedge clk);
        in_valid = 1'b0;
        got   = {out_valid, out_hit, out_abort, out_no_match, out_win, 1'b0};
        got_a = out_addr;
        exp   = {1'b1, kind == 2'd1, kind == 2'd2, kind == 2'd3, win, 1'b0};
        n_tests++;
        if (got !== exp || got_a !== xa) begin
            n_fail++;
            $display("FAIL %s addr %h: flags %b addr %h expected flags %b addr %h",
                     tag, a, got[5:1], got_a, exp[5:1], xa);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R9: reset state
        n_tests++;
        if (out_valid !== 1'b0 || out_hit !== 1'b0 || out_abort !== 1'b0 ||
            out_no_match !== 1'b0 || out_addr !== 32'h0) begin
            n_fail++;
            $display("FAIL R9 outputs in reset: valid %b addr %h expected 0 0", out_valid, out_addr);
        end
        chk_rd("R9", 3'd4, 32'h0);
        chk_rd("R9", 3'd0, 32'h0);
        rst_n = 1'b1;

        // R9: enables clear after reset, so a hit at base 0 aborts in window 0
        probe("R9/R5", 32'h0001_0000, 2'd2, 1'b0, 32'h0);

        wr(3'd0, 32'h8000_0000);
        wr(3'd1, 32'h7FFF_FFFF);
        wr(3'd2, 32'h1234_5678);
        wr(3'd3, 32'hC0FF_EE00);
        wr(3'd4, 32'h0000_0003);
        wr(3'd5, 32'hFFFF_FFFF);
        chk_rd("R7", 3'd1, 32'h4000_0000);
        chk_rd("R7", 3'd2, 32'h1234_0000);
        chk_rd("R7", 3'd3, 32'hC000_0000);
        chk_rd("R7", 3'd4, 32'h0000_0003);
        chk_rd("R7", 3'd5, 32'h0);

        for (int i = 0; i < NV; i++) begin
            string t;
            t = (V_KIND[i] == 2'd3) ? "R6" : (V_WIN[i] ? "R2/R3" : "R1/R3");
            probe(t, V_ADDR[i], V_KIND[i], V_WIN[i], V_XADDR[i]);
        end

        // R8: idle cycle after a result
        @(negedge clk);
        n_tests++;
        if (out_valid !== 1'b0 || out_hit !== 1'b0 || out_no_match !== 1'b0 || out_addr !== 32'h0) begin
            n_fail++;
            $display("FAIL R8 idle: valid %b addr %h expected 0 0", out_valid, out_addr);
        end

        // R4: overlap, window 0 placed inside window 1
        wr(3'd0, 32'h4010_0000);
        probe("R4", 32'h4010_0ABC, 2'd1, 1'b0, 32'h1234_0ABC);
        probe("R2", 32'h4020_0000, 2'd1, 1'b1, 32'hC020_0000);
        // R4/R5: window 0 disabled in overlap aborts even though window 1 is enabled
        wr(3'd4, 32'h0000_0002);
        probe("R4/R5", 32'h4010_0ABC, 2'd2, 1'b0, 32'h0);
        probe("R2", 32'h4020_0000, 2'd1, 1'b1, 32'hC020_0000);
        // R5: window 1 disabled
        wr(3'd4, 32'h0000_0000);
        probe("R5", 32'h4020_0000, 2'd2, 1'b1, 32'h0);
        probe("R6", 32'h8000_0000, 2'd3, 1'b0, 32'h0);

        finish_run();
    end

endmodule